// File: doc/BRIEF.md
# Two-Length Receive Sequencer with Arm Flags

This controller paces incoming transfers of two fixed lengths. While idle it watches a grant line. When a grant arrives it latches a length select that says which kind of transfer is coming. It then runs that transfer through its data beats and comes back to idle. A short transfer has one data beat, so its full cycle is two clocks. A long transfer has four data beats, so its full cycle is five clocks. The data path itself is outside this block.

Next to the sequencer sit two independent arm flags, one for each transfer length. Surrounding logic raises an arm request. The block answers with a one-cycle acknowledge code and shows the flag one cycle after that. A flag is consumed only by a complete transfer of its own length that began while the flag was already visible. Each flag takes a snapshot of its state at every transfer start, and that snapshot decides whether the transfer clears it. Arming during a transfer, or on the very edge that starts one, therefore never lets that transfer clear the flag. While the long flag qualifies a long transfer, a strobe marks the first three of its data beats.

Top module: `rx_len_seq`

## Requirements
- R1: A clock edge with `rst` high puts the block in idle (`idle_o`=1) with both flags clear, `ack_code_o`=0 and `data_strobe_o`=0. All of this is visible after the first reset edge, with no settling delay.
- R2: A grant sampled in idle with `long_sel_i`=0 gives exactly one cycle with `idle_o`=0, followed by idle. Grants sampled while not idle are ignored.
- R3: A grant sampled in idle with `long_sel_i`=1 gives exactly four cycles with `idle_o`=0, followed by idle.
- R4: The length is sampled only at the start edge. During a transfer, `hdr_long_o` holds the chosen length (1 = long) whatever `long_sel_i` does, and the transfer length does not change.
- R5: In idle, `hdr_long_o` equals `long_sel_i` combinationally. Toggling `long_sel_i` never changes either flag.
- R6: The cycle after an arm request is sampled, `ack_code_o` is 3 for a short request and 2 for a long request. Short wins when both are requested, and both flags are still set. The code is 0 when no request was sampled. The flag reads 1 one cycle after the code.
- R7: `short_armed_o` clears at the end of a completed short transfer that started while it read 1. Long transfers never clear it.
- R8: `long_armed_o` clears at the end of a completed long transfer that started while it read 1. Short transfers never clear it.
- R9: A flag armed on the start edge of a transfer, or during any of its data beats, survives the end of that transfer. Only the next full matching transfer clears it.
- R10: `data_strobe_o` is 1 in long data beats 1 to 3 of a transfer that started with `long_armed_o`=1, and 0 in beat 4 and everywhere else.
- R11: In idle with no grant, the block stays idle and both flags hold their values.
- R12: When a pending arm request and a qualifying clear land on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_i | input | 1 | Transfer grant, acted on only in idle |
| long_sel_i | input | 1 | Length select: 1 = long (four beats), 0 = short (one beat) |
| arm_short_i | input | 1 | Request to arm the short-transfer flag |
| arm_long_i | input | 1 | Request to arm the long-transfer flag |
| idle_o | output | 1 | High while no transfer is running |
| hdr_long_o | output | 1 | Header length: select in idle, latched length during a transfer |
| short_armed_o | output | 1 | Short-transfer arm flag |
| long_armed_o | output | 1 | Long-transfer arm flag |
| ack_code_o | output | 2 | Arm acknowledge: 3 short, 2 long, 0 none |
| data_strobe_o | output | 1 | Strobe for data beats 1 to 3 of a qualifying long transfer |

## Verification
The bench arms each flag on the start edge of a transfer and in the middle of its data beats. A design that snapshots its flags too late would let that transfer consume the new arm, so the flag would drop one transfer early. It switches the length select during both kinds of transfer. A design that samples the select outside idle would stretch or cut the running transfer, or move `hdr_long_o`. It runs transfers of the other length while a flag is armed, which catches a clear that ignores the length. It also re-arms a flag on the very edge where its clear lands, which catches clear taking priority over set. The strobe pattern is checked in the last data beat and in unqualified long transfers, so a strobe that is one beat too long or that ignores the snapshot shows up.

// File: rtl/rx_len_seq_pkg.sv
package rx_len_seq_pkg;

    typedef enum logic [1:0] {
        XK_IDLE  = 2'd0,
        XK_SHORT = 2'd1,
        XK_LONG  = 2'd2
    } xfer_kind_e;

    localparam int unsigned FLAG_SHORT = 0;
    localparam int unsigned FLAG_LONG  = 1;
    localparam int unsigned NUM_FLAGS  = 2;

    localparam logic [1:0] ACK_NONE  = 2'd0;
    localparam logic [1:0] ACK_LONG  = 2'd2;
    localparam logic [1:0] ACK_SHORT = 2'd3;

    typedef struct packed {
        logic long_req;
        logic short_req;
    } arm_req_t;

    function automatic logic [1:0] ack_encode(arm_req_t r);
        if (r.short_req)     return ACK_SHORT;
        else if (r.long_req) return ACK_LONG;
        else                 return ACK_NONE;
    endfunction

endpackage

// File: rtl/rx_len_sequencer.sv
module rx_len_sequencer
    import rx_len_seq_pkg::*;
#(
    parameter int unsigned SHORT_BEATS = 1,
    parameter int unsigned LONG_BEATS  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic grant_i,
    input  logic long_sel_i,
    output logic idle_o,
    output logic is_long_o,
    output logic start_o,
    output logic done_short_o,
    output logic done_long_o,
    output logic strobe_win_o
);
    localparam int unsigned CW = $clog2(LONG_BEATS + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_BEATS);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_BEATS);

    xfer_kind_e     kind_q, kind_d;
    logic [CW-1:0]  beat_q, beat_d;
    logic           last_beat;

    assign idle_o    = (kind_q == XK_IDLE);
    assign is_long_o = (kind_q == XK_LONG);
    assign start_o   = idle_o && grant_i;
    assign last_beat = ((kind_q == XK_SHORT) && (beat_q == SHORT_LAST)) ||
                       ((kind_q == XK_LONG)  && (beat_q == LONG_LAST));
    assign done_short_o = (kind_q == XK_SHORT) && last_beat;
    assign done_long_o  = (kind_q == XK_LONG)  && last_beat;
    assign strobe_win_o = (kind_q == XK_LONG) && (beat_q < LONG_LAST);

    always_comb begin
        kind_d = kind_q;
        beat_d = beat_q;
        if (idle_o) begin
            if (grant_i) begin
                kind_d = long_sel_i ? XK_LONG : XK_SHORT;
                beat_d = CW'(1);
            end
        end else if (last_beat) begin
            kind_d = XK_IDLE;
            beat_d = '0;
        end else begin
            beat_d = beat_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= XK_IDLE;
            beat_q <= '0;
        end else begin
            kind_q <= kind_d;
            beat_q <= beat_d;
        end
    end

    assert_grant_leaves_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (idle_o && grant_i) |=> !idle_o);
    assert_short_one_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (idle_o && grant_i && !long_sel_i) |=> !idle_o ##1 idle_o);
    assert_long_keeps_running_R3: assert property (@(posedge clk) disable iff (rst)
        (is_long_o && (beat_q < LONG_LAST)) |=> is_long_o);
    assert_kind_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !idle_o |=> (idle_o || $stable(kind_q)));
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (idle_o && !grant_i) |=> idle_o);

endmodule

// File: rtl/rx_arm_flag.sv
module rx_arm_flag (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic start_i,
    input  logic done_i,
    output logic flag_o,
    output logic tag_o
);
    logic pend_q;
    logic flag_q;
    logic tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            flag_q <= 1'b0;
            tag_q  <= 1'b0;
        end else begin
            pend_q <= req_i;
            if (start_i)
                tag_q <= flag_q;
            if (pend_q)
                flag_q <= 1'b1;
            else if (done_i && tag_q)
                flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign tag_o  = tag_q;

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> flag_q);
    assert_untagged_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !tag_q) |=> flag_q);
    assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !pend_q) |=> !flag_q);

endmodule

// File: rtl/rx_ack_encoder.sv
module rx_ack_encoder
    import rx_len_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  arm_req_t   req_i,
    output logic [1:0] code_o
);
    logic [1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) code_q <= ACK_NONE;
        else     code_q <= ack_encode(req_i);
    end

    assign code_o = code_q;

    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        ((req_i.short_req || req_i.long_req) == 1'b0) |=> (code_q == ACK_NONE));

endmodule

// File: rtl/rx_len_seq.sv
module rx_len_seq
    import rx_len_seq_pkg::*;
#(
    parameter int unsigned SHORT_BEATS = 1,
    parameter int unsigned LONG_BEATS  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       grant_i,
    input  logic       long_sel_i,
    input  logic       arm_short_i,
    input  logic       arm_long_i,
    output logic       idle_o,
    output logic       hdr_long_o,
    output logic       short_armed_o,
    output logic       long_armed_o,
    output logic [1:0] ack_code_o,
    output logic       data_strobe_o
);
    logic is_long, start, done_short, done_long, strobe_win;
    logic [NUM_FLAGS-1:0] req_vec, done_vec, flag_vec, tag_vec;
    arm_req_t arm_req;

    assign arm_req.short_req = arm_short_i;
    assign arm_req.long_req  = arm_long_i;

    rx_len_sequencer #(
        .SHORT_BEATS (SHORT_BEATS),
        .LONG_BEATS  (LONG_BEATS)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .grant_i      (grant_i),
        .long_sel_i   (long_sel_i),
        .idle_o       (idle_o),
        .is_long_o    (is_long),
        .start_o      (start),
        .done_short_o (done_short),
        .done_long_o  (done_long),
        .strobe_win_o (strobe_win)
    );

    assign req_vec[FLAG_SHORT]  = arm_short_i;
    assign req_vec[FLAG_LONG]   = arm_long_i;
    assign done_vec[FLAG_SHORT] = done_short;
    assign done_vec[FLAG_LONG]  = done_long;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        rx_arm_flag u_flag (
            .clk     (clk),
            .rst     (rst),
            .req_i   (req_vec[i]),
            .start_i (start),
            .done_i  (done_vec[i]),
            .flag_o  (flag_vec[i]),
            .tag_o   (tag_vec[i])
        );
    end

    rx_ack_encoder u_ack (
        .clk    (clk),
        .rst    (rst),
        .req_i  (arm_req),
        .code_o (ack_code_o)
    );

    assign short_armed_o = flag_vec[FLAG_SHORT];
    assign long_armed_o  = flag_vec[FLAG_LONG];
    assign hdr_long_o    = idle_o ? long_sel_i : is_long;
    assign data_strobe_o = strobe_win && tag_vec[FLAG_LONG];

    assert_hdr_held_R4: assert property (@(posedge clk) disable iff (rst)
        !idle_o |=> (idle_o || $stable(hdr_long_o)));
    assert_strobe_context_R10: assert property (@(posedge clk) disable iff (rst)
        data_strobe_o |-> (!idle_o && hdr_long_o && long_armed_o));
    assert_short_ack_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_code_o == ACK_SHORT) |=> short_armed_o);
    assert_long_ack_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_code_o == ACK_LONG) |=> long_armed_o);
    assert_short_not_by_long_R7: assert property (@(posedge clk) disable iff (rst)
        (short_armed_o && !done_short) |=> short_armed_o);
    assert_long_not_by_short_R8: assert property (@(posedge clk) disable iff (rst)
        (long_armed_o && !done_long) |=> long_armed_o);

endmodule

// File: tb/sim_rx_len_seq.sv
`timescale 1ns/100ps
module sim_rx_len_seq;
    logic clk = 1'b0;
    logic rst, grant, lsel, as_r, al_r;
    logic idle, hdr, s_arm, l_arm, stb;
    logic [1:0] ack;

    typedef struct {
        logic [6:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rx_len_seq u0 (
        .clk(clk), .rst(rst), .grant_i(grant), .long_sel_i(lsel),
        .arm_short_i(as_r), .arm_long_i(al_r),
        .idle_o(idle), .hdr_long_o(hdr), .short_armed_o(s_arm),
        .long_armed_o(l_arm), .ack_code_o(ack), .data_strobe_o(stb)
    );

    // expected field order: {idle, hdr, short_flag, long_flag, ack[1:0], strobe}
    task automatic t(input logic r, input logic g, input logic l, input logic a_s, input logic a_l,
                     input logic e_idle, input logic e_hdr, input logic e_s, input logic e_l,
                     input logic [1:0] e_ack, input logic e_stb, input string req);
        item_t it;
        @(negedge clk);
        rst = r; grant = g; lsel = l; as_r = a_s; al_r = a_l;
        it.exp = {e_idle, e_hdr, e_s, e_l, e_ack, e_stb};
        it.req = req;
        q.push_back(it);
    endtask

    // monitor: compares outputs just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                logic [6:0] act;
                it = q.pop_front();
                act = {idle, hdr, s_arm, l_arm, ack, stb};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %b expected %b (idle,hdr,s,l,ack,stb)", it.req, act, it.exp);
                end
            end
        end
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; grant = 0; lsel = 0; as_r = 0; al_r = 0;
        // R1 reset state
        t(1,0,0,0,0, 1,0,0,0,2'd0,0, "R1");
        t(1,0,0,0,0, 1,0,0,0,2'd0,0, "R1");
        // R11 idle holds
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R11");
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R11");
        // R2 short transfer
        t(0,1,0,0,0, 0,0,0,0,2'd0,0, "R2");
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R2");
        // R4 select change during short beat, R5 idle follows select
        t(0,1,0,0,0, 0,0,0,0,2'd0,0, "R4");
        t(0,0,1,0,0, 1,1,0,0,2'd0,0, "R5");
        // R3 long transfer with select dropped mid-way (R4)
        t(0,1,1,0,0, 0,1,0,0,2'd0,0, "R3");
        t(0,1,0,0,0, 0,1,0,0,2'd0,0, "R4");
        t(0,1,0,0,0, 0,1,0,0,2'd0,0, "R4");
        t(0,1,0,0,0, 0,1,0,0,2'd0,0, "R3");
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R3");
        // R6 arm short
        t(0,0,0,1,0, 1,0,0,0,2'd3,0, "R6");
        t(0,0,0,0,0, 1,0,1,0,2'd0,0, "R6");
        // R5 select toggle leaves flags
        t(0,0,1,0,0, 1,1,1,0,2'd0,0, "R5");
        t(0,0,0,0,0, 1,0,1,0,2'd0,0, "R5");
        // R7 long transfer does not clear short flag
        t(0,1,1,0,0, 0,1,1,0,2'd0,0, "R7");
        t(0,0,1,0,0, 0,1,1,0,2'd0,0, "R7");
        t(0,0,1,0,0, 0,1,1,0,2'd0,0, "R7");
        t(0,0,1,0,0, 0,1,1,0,2'd0,0, "R7");
        t(0,0,0,0,0, 1,0,1,0,2'd0,0, "R7");
        // R7 short transfer clears
        t(0,1,0,0,0, 0,0,1,0,2'd0,0, "R7");
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R7");
        // R9 arm on start edge
        t(0,1,0,1,0, 0,0,0,0,2'd3,0, "R9");
        t(0,0,0,0,0, 1,0,1,0,2'd0,0, "R9");
        t(0,1,0,0,0, 0,0,1,0,2'd0,0, "R9");
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R9");
        // R9 arm during short data beat
        t(0,1,0,0,0, 0,0,0,0,2'd0,0, "R9");
        t(0,0,0,1,0, 1,0,0,0,2'd3,0, "R9");
        t(0,0,0,0,0, 1,0,1,0,2'd0,0, "R9");
        t(0,1,0,0,0, 0,0,1,0,2'd0,0, "R9");
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R9");
        // R6 arm long
        t(0,0,1,0,1, 1,1,0,0,2'd2,0, "R6");
        t(0,0,1,0,0, 1,1,0,1,2'd0,0, "R6");
        // R8 short transfer leaves long flag
        t(0,1,0,0,0, 0,0,0,1,2'd0,0, "R8");
        t(0,0,0,0,0, 1,0,0,1,2'd0,0, "R8");
        // R8/R10 qualifying long transfer
        t(0,1,1,0,0, 0,1,0,1,2'd0,1, "R10");
        t(0,0,1,0,0, 0,1,0,1,2'd0,1, "R10");
        t(0,0,1,0,0, 0,1,0,1,2'd0,1, "R10");
        t(0,0,1,0,0, 0,1,0,1,2'd0,0, "R10");
        t(0,0,1,0,0, 1,1,0,0,2'd0,0, "R8");
        // R9 arm long during beat 1 of a long transfer
        t(0,1,1,0,0, 0,1,0,0,2'd0,0, "R10");
        t(0,0,1,0,1, 0,1,0,0,2'd2,0, "R9");
        t(0,0,1,0,0, 0,1,0,1,2'd0,0, "R10");
        t(0,0,1,0,0, 0,1,0,1,2'd0,0, "R9");
        t(0,0,1,0,0, 1,1,0,1,2'd0,0, "R9");
        t(0,1,1,0,0, 0,1,0,1,2'd0,1, "R10");
        t(0,0,1,0,0, 0,1,0,1,2'd0,1, "R10");
        t(0,0,1,0,0, 0,1,0,1,2'd0,1, "R10");
        t(0,0,1,0,0, 0,1,0,1,2'd0,0, "R10");
        t(0,0,1,0,0, 1,1,0,0,2'd0,0, "R9");
        // R12 re-arm lands on the clearing edge
        t(0,0,0,1,0, 1,0,0,0,2'd3,0, "R6");
        t(0,0,0,0,0, 1,0,1,0,2'd0,0, "R6");
        t(0,1,0,1,0, 0,0,1,0,2'd3,0, "R12");
        t(0,0,0,0,0, 1,0,1,0,2'd0,0, "R12");
        t(0,1,0,0,0, 0,0,1,0,2'd0,0, "R7");
        t(0,0,0,0,0, 1,0,0,0,2'd0,0, "R7");
        // R6 both requests at once
        t(0,0,0,1,1, 1,0,0,0,2'd3,0, "R6");
        t(0,0,0,0,0, 1,0,1,1,2'd0,0, "R6");
        // R11 idle holds flags
        t(0,0,0,0,0, 1,0,1,1,2'd0,0, "R11");
        t(0,0,0,0,0, 1,0,1,1,2'd0,0, "R11");
        // R1 reset clears armed flags
        t(1,0,0,0,0, 1,0,0,0,2'd0,0, "R1");
        @(posedge clk);
        #2;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule